// File: doc/BRIEF.md
# Operand Stage Hazard and Forwarding Unit

This block is the operand-preparation stage of an in-order 32-bit pipeline. Each cycle it takes one decoded instruction, with up to two source register indices and the values the register file returned for them. It compares those indices with the destination registers of the instructions now in the execute (EX) and memory-access (MA) stages. A result that MA already holds is substituted straight into the operand. A result that EX will be able to pick up one cycle later is passed on as a forwarding hint. A dependence that neither path can cover holds the instruction back and sends a bubble downstream.

For loads and stores the stage also adds the sign-extended immediate to the base operand. The transfer address is then ready in a register and can drive the data bus in the next stage. Because the address is formed this early, the base operand has stricter hazard rules than ordinary operands. An instruction that was repaired after a fetch error is only let through once both downstream stages are empty.

Top module: `opStage`

## Requirements
- R1: While `rstN` is low, and on the first edge after it, every registered output is zero. The zero state is the bubble.
- R2: A source index of 0 gives an operand of zero whatever the register file returns, and it never causes a stall or sets a forwarding hint.
- R3: An operand matches a stage when that stage is valid, writes a register equal to the operand's nonzero index, and the operand is used. Source 1 counts as used whenever the instruction is a load or store. If MA matches, EX does not, and `maReady` is 1, the operand takes `maResult` instead of the register file data.
- R4: If EX matches an operand and `exLate` is 0, the stage does not stall (unless R8 applies). It sets the hint bit "take from MA next cycle", and the operand keeps the register file data. The hint bits are: bit 0 for operand 1 from MA, bit 1 for operand 1 from writeback, bit 2 for operand 2 from MA, bit 3 for operand 2 from writeback.
- R5: If MA matches an operand, EX does not, and `maReady` is 0, the stage does not stall (unless R8 applies). It sets that operand's "take from writeback" hint bit.
- R6: When both EX and MA match the same operand, only the EX match is used: no MA substitution and no writeback hint.
- R7: A stall is raised when EX matches either operand and `exLate` is 1.
- R8: For a load or store, a stall is raised when the base (source 1) matches EX, or matches MA while `maReady` is 0.
- R9: A stall is raised when the instruction carries the repaired-after-fetch flag and either `exValid` or `maValid` is 1.
- R10: For a load or store, `outAddr` holds operand 1 (after R2/R3) plus `inImm` modulo 2^32. For any other instruction it holds 0.
- R11: `stall` is combinational and equals `inValid` AND (any of R7, R8, R9). After an edge where the instruction was invalid or stalled, every registered output is zero.
- R12: After an edge that accepts an instruction, `outValid` is 1 and `outRd`, `outFunc`, `outCtrl` and `outMiscon` equal the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | An instruction is present |
| inRs1 | input | 5 | Source 1 index |
| inRs2 | input | 5 | Source 2 index |
| inUseRs1 | input | 1 | Source 1 is read |
| inUseRs2 | input | 1 | Source 2 is read |
| inIsLsu | input | 1 | Instruction is a load or store |
| inFixed | input | 1 | Instruction was repaired after fetch |
| inRd | input | 5 | Destination index |
| inFunc | input | 4 | Function code |
| inCtrl | input | 7 | Control bits |
| inMiscon | input | 3 | Misconduct flags |
| inImm | input | 32 | Sign-extended immediate |
| rfData1 | input | 32 | Register file data for source 1 |
| rfData2 | input | 32 | Register file data for source 2 |
| exValid | input | 1 | EX holds an instruction |
| exWrites | input | 1 | EX instruction writes a register |
| exRd | input | 5 | EX destination index |
| exLate | input | 1 | EX instruction produces its result in MA |
| maValid | input | 1 | MA holds an instruction |
| maWrites | input | 1 | MA instruction writes a register |
| maRd | input | 5 | MA destination index |
| maReady | input | 1 | MA result is available now |
| maResult | input | 32 | MA result value |
| stall | output | 1 | Hold the instruction upstream |
| outValid | output | 1 | Registered valid to EX |
| outOp1 | output | 32 | Registered operand 1 |
| outOp2 | output | 32 | Registered operand 2 |
| outAddr | output | 32 | Registered transfer address |
| outRd | output | 5 | Registered destination |
| outFunc | output | 4 | Registered function code |
| outCtrl | output | 7 | Registered control bits |
| outFwd | output | 4 | Registered forwarding hints |
| outMiscon | output | 3 | Registered misconduct flags |

## Verification
Directed patterns put one producer at a time in EX or MA, with the result ready or late. This separates substitution, each hint bit and each stall cause. A case with both stages writing the same register, but with different readiness, shows whether EX takes priority. Index-zero cases use nonzero register data and matching producers, so a missing zero rule shows up in the operand value. Random traffic over a small set of register indices then produces many overlapping matches. The bench compares every output against a behavioural model on every cycle.

// File: rtl/opPkg.sv
package opPkg;
  localparam int FWD_W = 4;

  typedef struct packed {
    logic             load;
    logic             selMa1;
    logic             selMa2;
    logic             zero1;
    logic             zero2;
    logic [FWD_W-1:0] fwd;
  } opStrobe_t;
endpackage

// File: rtl/opCtrl.sv
module opCtrl
  import opPkg::*;
#(
  parameter int REGW = 5
) (
  input  logic            inValid,
  input  logic [REGW-1:0] inRs1,
  input  logic [REGW-1:0] inRs2,
  input  logic            inUseRs1,
  input  logic            inUseRs2,
  input  logic            inIsLsu,
  input  logic            inFixed,
  input  logic            exValid,
  input  logic            exWrites,
  input  logic [REGW-1:0] exRd,
  input  logic            exLate,
  input  logic            maValid,
  input  logic            maWrites,
  input  logic [REGW-1:0] maRd,
  input  logic            maReady,
  output logic            stall,
  output opStrobe_t       strobe
);
  localparam int NSRC = 2;

  logic [REGW-1:0] rsIdx [NSRC];
  logic [NSRC-1:0] rsUse;
  logic [NSRC-1:0] hitEx, hitMa, isZero, lateHaz, selMa;
  logic [FWD_W-1:0] hint;
  logic lsuHaz, fixHaz;

  assign rsIdx[0] = inRs1;
  assign rsIdx[1] = inRs2;
  assign rsUse[0] = inUseRs1 | inIsLsu;
  assign rsUse[1] = inUseRs2;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    assign isZero[k]     = (rsIdx[k] == '0);
    assign hitEx[k]      = rsUse[k] & ~isZero[k] & exValid & exWrites & (exRd == rsIdx[k]);
    assign hitMa[k]      = rsUse[k] & ~isZero[k] & maValid & maWrites & (maRd == rsIdx[k]);
    assign lateHaz[k]    = hitEx[k] & exLate;
    assign selMa[k]      = ~hitEx[k] & hitMa[k] & maReady;
    assign hint[2*k]     = hitEx[k] & ~exLate;
    assign hint[2*k+1]   = ~hitEx[k] & hitMa[k] & ~maReady;
  end

  assign lsuHaz = inIsLsu & (hitEx[0] | (hitMa[0] & ~maReady));
  assign fixHaz = inFixed & (exValid | maValid);
  assign stall  = inValid & ((|lateHaz) | lsuHaz | fixHaz);

  always_comb begin
    strobe.load   = inValid & ~stall;
    strobe.selMa1 = selMa[0];
    strobe.selMa2 = selMa[1];
    strobe.zero1  = isZero[0];
    strobe.zero2  = isZero[1];
    strobe.fwd    = hint;
  end
endmodule

// File: rtl/opDatapath.sv
module opDatapath
  import opPkg::*;
#(
  parameter int XLEN  = 32,
  parameter int REGW  = 5,
  parameter int FUNCW = 4,
  parameter int CTRLW = 7,
  parameter int MISW  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  opStrobe_t        strobe,
  input  logic [XLEN-1:0]  rfData1,
  input  logic [XLEN-1:0]  rfData2,
  input  logic [XLEN-1:0]  maResult,
  input  logic [XLEN-1:0]  inImm,
  input  logic             inIsLsu,
  input  logic [REGW-1:0]  inRd,
  input  logic [FUNCW-1:0] inFunc,
  input  logic [CTRLW-1:0] inCtrl,
  input  logic [MISW-1:0]  inMiscon,
  output logic             outValid,
  output logic [XLEN-1:0]  outOp1,
  output logic [XLEN-1:0]  outOp2,
  output logic [XLEN-1:0]  outAddr,
  output logic [REGW-1:0]  outRd,
  output logic [FUNCW-1:0] outFunc,
  output logic [CTRLW-1:0] outCtrl,
  output logic [FWD_W-1:0] outFwd,
  output logic [MISW-1:0]  outMiscon
);
  logic [XLEN-1:0] op1, op2, addr;

  always_comb begin
    op1  = strobe.zero1 ? '0 : (strobe.selMa1 ? maResult : rfData1);
    op2  = strobe.zero2 ? '0 : (strobe.selMa2 ? maResult : rfData2);
    addr = inIsLsu ? (op1 + inImm) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strobe.load) begin
      outValid  <= 1'b0;
      outOp1    <= '0;
      outOp2    <= '0;
      outAddr   <= '0;
      outRd     <= '0;
      outFunc   <= '0;
      outCtrl   <= '0;
      outFwd    <= '0;
      outMiscon <= '0;
    end else begin
      outValid  <= 1'b1;
      outOp1    <= op1;
      outOp2    <= op2;
      outAddr   <= addr;
      outRd     <= inRd;
      outFunc   <= inFunc;
      outCtrl   <= inCtrl;
      outFwd    <= strobe.fwd;
      outMiscon <= inMiscon;
    end
  end

  AST_HINT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(outFwd[1:0]) && $onehot0(outFwd[3:2])); // R6
endmodule

// File: rtl/opStage.sv
module opStage
  import opPkg::*;
#(
  parameter int XLEN  = 32,
  parameter int REGW  = 5,
  parameter int FUNCW = 4,
  parameter int CTRLW = 7,
  parameter int MISW  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [REGW-1:0]  inRs1,
  input  logic [REGW-1:0]  inRs2,
  input  logic             inUseRs1,
  input  logic             inUseRs2,
  input  logic             inIsLsu,
  input  logic             inFixed,
  input  logic [REGW-1:0]  inRd,
  input  logic [FUNCW-1:0] inFunc,
  input  logic [CTRLW-1:0] inCtrl,
  input  logic [MISW-1:0]  inMiscon,
  input  logic [XLEN-1:0]  inImm,
  input  logic [XLEN-1:0]  rfData1,
  input  logic [XLEN-1:0]  rfData2,
  input  logic             exValid,
  input  logic             exWrites,
  input  logic [REGW-1:0]  exRd,
  input  logic             exLate,
  input  logic             maValid,
  input  logic             maWrites,
  input  logic [REGW-1:0]  maRd,
  input  logic             maReady,
  input  logic [XLEN-1:0]  maResult,
  output logic             stall,
  output logic             outValid,
  output logic [XLEN-1:0]  outOp1,
  output logic [XLEN-1:0]  outOp2,
  output logic [XLEN-1:0]  outAddr,
  output logic [REGW-1:0]  outRd,
  output logic [FUNCW-1:0] outFunc,
  output logic [CTRLW-1:0] outCtrl,
  output logic [FWD_W-1:0] outFwd,
  output logic [MISW-1:0]  outMiscon
);
  opStrobe_t strobe;

  opCtrl #(.REGW(REGW)) ctrl_i (
    .inValid(inValid), .inRs1(inRs1), .inRs2(inRs2),
    .inUseRs1(inUseRs1), .inUseRs2(inUseRs2), .inIsLsu(inIsLsu), .inFixed(inFixed),
    .exValid(exValid), .exWrites(exWrites), .exRd(exRd), .exLate(exLate),
    .maValid(maValid), .maWrites(maWrites), .maRd(maRd), .maReady(maReady),
    .stall(stall), .strobe(strobe)
  );

  opDatapath #(.XLEN(XLEN), .REGW(REGW), .FUNCW(FUNCW), .CTRLW(CTRLW), .MISW(MISW)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rfData1(rfData1), .rfData2(rfData2), .maResult(maResult), .inImm(inImm),
    .inIsLsu(inIsLsu), .inRd(inRd), .inFunc(inFunc), .inCtrl(inCtrl), .inMiscon(inMiscon),
    .outValid(outValid), .outOp1(outOp1), .outOp2(outOp2), .outAddr(outAddr),
    .outRd(outRd), .outFunc(outFunc), .outCtrl(outCtrl), .outFwd(outFwd), .outMiscon(outMiscon)
  );

  AST_BUBBLE_AFTER_STALL: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> (!outValid && outCtrl == '0 && outFwd == '0)); // R11

  AST_ZERO_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !stall && inRs1 == '0 && inRs2 == '0) |=> (outOp1 == '0 && outOp2 == '0)); // R2

  AST_FIX_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inFixed && (exValid || maValid)) |-> stall); // R9

  AST_LSU_BASE_EX: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inIsLsu && exValid && exWrites && inRs1 != '0 && exRd == inRs1) |-> stall); // R8

  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !stall) |=> outValid); // R12
endmodule

// File: tb/opStage_tb.sv
module opStage_tb_top;
  logic clk = 1'b0;
  logic rstN;
  logic inValid, inUseRs1, inUseRs2, inIsLsu, inFixed;
  logic [4:0] inRs1, inRs2, inRd;
  logic [3:0] inFunc;
  logic [6:0] inCtrl;
  logic [2:0] inMiscon;
  logic [31:0] inImm, rfData1, rfData2, maResult;
  logic exValid, exWrites, exLate, maValid, maWrites, maReady;
  logic [4:0] exRd, maRd;
  logic stall, outValid;
  logic [31:0] outOp1, outOp2, outAddr;
  logic [4:0] outRd;
  logic [3:0] outFunc;
  logic [6:0] outCtrl;
  logic [3:0] outFwd;
  logic [2:0] outMiscon;

  int nChk = 0;
  int nBad = 0;
  bit done = 0;

  bit        eValid;
  bit [31:0] eOp1, eOp2, eAddr;
  bit [4:0]  eRd;
  bit [3:0]  eFunc, eFwd;
  bit [6:0]  eCtrl;
  bit [2:0]  eMis;

  always #10 clk = ~clk;

  opStage dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inRs1(inRs1), .inRs2(inRs2),
    .inUseRs1(inUseRs1), .inUseRs2(inUseRs2), .inIsLsu(inIsLsu), .inFixed(inFixed),
    .inRd(inRd), .inFunc(inFunc), .inCtrl(inCtrl), .inMiscon(inMiscon), .inImm(inImm),
    .rfData1(rfData1), .rfData2(rfData2), .exValid(exValid), .exWrites(exWrites),
    .exRd(exRd), .exLate(exLate), .maValid(maValid), .maWrites(maWrites), .maRd(maRd),
    .maReady(maReady), .maResult(maResult), .stall(stall), .outValid(outValid),
    .outOp1(outOp1), .outOp2(outOp2), .outAddr(outAddr), .outRd(outRd), .outFunc(outFunc),
    .outCtrl(outCtrl), .outFwd(outFwd), .outMiscon(outMiscon)
  );

  task automatic chk(string tag, string field, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, field, act, exp);
    end
  endtask

  task automatic clearIn();
    inValid = 0; inUseRs1 = 0; inUseRs2 = 0; inIsLsu = 0; inFixed = 0;
    inRs1 = 0; inRs2 = 0; inRd = 0; inFunc = 0; inCtrl = 0; inMiscon = 0; inImm = 0;
    rfData1 = 32'h1111_1111; rfData2 = 32'h2222_2222; maResult = 32'hAAAA_0000;
    exValid = 0; exWrites = 0; exRd = 0; exLate = 0;
    maValid = 0; maWrites = 0; maRd = 0; maReady = 0;
  endtask

  // Behavioural reference: expected stall and next registered outputs from current inputs
  task automatic model(output bit st);
    bit use1, exM1, exM2, maM1, maM2;
    bit [31:0] o1, o2;
    use1 = inUseRs1 || inIsLsu;
    exM1 = use1 && inRs1 != 0 && exValid && exWrites && exRd == inRs1;
    maM1 = use1 && inRs1 != 0 && maValid && maWrites && maRd == inRs1;
    exM2 = inUseRs2 && inRs2 != 0 && exValid && exWrites && exRd == inRs2;
    maM2 = inUseRs2 && inRs2 != 0 && maValid && maWrites && maRd == inRs2;
    st = 0;
    if (exLate && (exM1 || exM2)) st = 1;                 // R7
    if (inIsLsu && (exM1 || (maM1 && !maReady))) st = 1;  // R8
    if (inFixed && (exValid || maValid)) st = 1;          // R9
    st = st && inValid;                                   // R11
    if (inRs1 == 0) o1 = 0; else if (!exM1 && maM1 && maReady) o1 = maResult; else o1 = rfData1;
    if (inRs2 == 0) o2 = 0; else if (!exM2 && maM2 && maReady) o2 = maResult; else o2 = rfData2;
    if (!inValid || st) begin
      eValid = 0; eOp1 = 0; eOp2 = 0; eAddr = 0; eRd = 0; eFunc = 0; eCtrl = 0; eFwd = 0; eMis = 0;
    end else begin
      eValid = 1; eOp1 = o1; eOp2 = o2;
      eAddr = inIsLsu ? o1 + inImm : 0;
      eRd = inRd; eFunc = inFunc; eCtrl = inCtrl; eMis = inMiscon;
      eFwd[0] = exM1 && !exLate;
      eFwd[1] = !exM1 && maM1 && !maReady;
      eFwd[2] = exM2 && !exLate;
      eFwd[3] = !exM2 && maM2 && !maReady;
    end
  endtask

  // Inputs were driven at a negedge; check stall, clock once, check registers at next negedge
  task automatic cycle(string tag);
    bit st;
    #1;
    model(st);
    chk(tag, "stall", {31'b0, stall}, {31'b0, st});
    @(posedge clk);
    @(negedge clk);
    chk(tag, "outValid", {31'b0, outValid}, {31'b0, eValid});
    chk(tag, "outOp1", outOp1, eOp1);
    chk(tag, "outOp2", outOp2, eOp2);
    chk(tag, "outAddr", outAddr, eAddr);
    chk(tag, "outRd", {27'b0, outRd}, {27'b0, eRd});
    chk(tag, "outFunc", {28'b0, outFunc}, {28'b0, eFunc});
    chk(tag, "outCtrl", {25'b0, outCtrl}, {25'b0, eCtrl});
    chk(tag, "outFwd", {28'b0, outFwd}, {28'b0, eFwd});
    chk(tag, "outMiscon", {29'b0, outMiscon}, {29'b0, eMis});
  endtask

  task automatic baseInstr();
    inValid = 1; inUseRs1 = 1; inUseRs2 = 1; inRd = 5'd9; inFunc = 4'hA;
    inCtrl = 7'h55; inMiscon = 3'h5; inRs1 = 5'd3; inRs2 = 5'd4;
  endtask

  initial begin
    clearIn();
    rstN = 0;
    baseInstr();
    @(negedge clk); @(negedge clk);
    // R1: reset clears outputs even with a valid instruction present
    chk("R1", "outValid", {31'b0, outValid}, 32'd0);
    chk("R1", "outOp1", outOp1, 32'd0);
    chk("R1", "outCtrl", {25'b0, outCtrl}, 32'd0);
    chk("R1", "outFwd", {28'b0, outFwd}, 32'd0);
    rstN = 1;
    clearIn();
    cycle("R1 idle");

    // R12: plain pass-through, no producers
    baseInstr(); cycle("R12");
    // R2: index zero with matching producers everywhere
    baseInstr(); inRs1 = 0; inRs2 = 0; inIsLsu = 1; inImm = 32'h40;
    exValid = 1; exWrites = 1; exRd = 0; exLate = 1; maValid = 1; maWrites = 1; maRd = 0;
    cycle("R2");
    // R3: MA ready substitution on operand 2
    baseInstr(); maValid = 1; maWrites = 1; maRd = 5'd4; maReady = 1; maResult = 32'hCAFE_F00D;
    cycle("R3");
    // R3: unused source gets no substitution
    baseInstr(); inUseRs2 = 0; maValid = 1; maWrites = 1; maRd = 5'd4; maReady = 1;
    cycle("R3 unused");
    // R4: EX early producer on operand 1 -> hint bit 0
    baseInstr(); exValid = 1; exWrites = 1; exRd = 5'd3; cycle("R4");
    // R5: MA not-ready producer on operand 2 -> hint bit 3
    baseInstr(); maValid = 1; maWrites = 1; maRd = 5'd4; cycle("R5");
    // R6: both stages write source 1, MA ready: EX wins
    baseInstr(); exValid = 1; exWrites = 1; exRd = 5'd3;
    maValid = 1; maWrites = 1; maRd = 5'd3; maReady = 1; cycle("R6 ready");
    baseInstr(); exValid = 1; exWrites = 1; exRd = 5'd4;
    maValid = 1; maWrites = 1; maRd = 5'd4; maReady = 0; cycle("R6 late");
    // R7: late EX producer on operand 2
    baseInstr(); exValid = 1; exWrites = 1; exRd = 5'd4; exLate = 1; cycle("R7");
    // R7: EX not writing -> no stall
    baseInstr(); exValid = 1; exWrites = 0; exRd = 5'd4; exLate = 1; cycle("R7 nowrite");
    // R8: load base from EX
    baseInstr(); inIsLsu = 1; inUseRs1 = 0; exValid = 1; exWrites = 1; exRd = 5'd3; cycle("R8 ex");
    // R8: load base from MA not ready
    baseInstr(); inIsLsu = 1; maValid = 1; maWrites = 1; maRd = 5'd3; cycle("R8 ma");
    // R10: load base forwarded from ready MA, negative immediate
    baseInstr(); inIsLsu = 1; inImm = 32'hFFFF_FFF0; maValid = 1; maWrites = 1; maRd = 5'd3;
    maReady = 1; maResult = 32'h0000_1000; cycle("R10");
    baseInstr(); inIsLsu = 1; inImm = 32'h0000_0010; rfData1 = 32'hFFFF_FFF8; cycle("R10 wrap");
    // R9: repaired instruction with MA busy, then empty pipeline
    baseInstr(); inFixed = 1; maValid = 1; cycle("R9 busy");
    baseInstr(); inFixed = 1; cycle("R9 empty");
    // R11: stall bubble followed by acceptance
    baseInstr(); exValid = 1; exWrites = 1; exRd = 5'd3; exLate = 1; cycle("R11 stall");
    baseInstr(); cycle("R11 release");

    // Random traffic over a small index set
    for (int i = 0; i < 3000; i++) begin
      inValid = ($urandom_range(0, 7) != 0);
      inUseRs1 = $urandom_range(0, 1); inUseRs2 = $urandom_range(0, 1);
      inIsLsu = ($urandom_range(0, 3) == 0); inFixed = ($urandom_range(0, 7) == 0);
      inRs1 = 5'($urandom_range(0, 3)); inRs2 = 5'($urandom_range(0, 3));
      inRd = 5'($urandom); inFunc = 4'($urandom); inCtrl = 7'($urandom); inMiscon = 3'($urandom);
      inImm = $urandom; rfData1 = $urandom; rfData2 = $urandom; maResult = $urandom;
      exValid = $urandom_range(0, 1); exWrites = $urandom_range(0, 1);
      exRd = 5'($urandom_range(0, 3)); exLate = $urandom_range(0, 1);
      maValid = $urandom_range(0, 1); maWrites = $urandom_range(0, 1);
      maRd = 5'($urandom_range(0, 3)); maReady = $urandom_range(0, 1);
      cycle("R12 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule